// File: doc/BRIEF.md
# DDR SDRAM Command Sequencer

This block is the control state machine of a DDR SDRAM controller. Once reset is released it brings the memory up by itself. It closes all banks, writes the extended and base mode registers, closes all banks again and issues two auto-refresh commands. The mode register is set for a burst of four with a CAS latency of two. After that it raises `init_done` and starts to take requests.

Requests come in on three level inputs: read, write and refresh. The sequencer samples them only while it is idle. For a read or write it latches the row, column and bank, opens the row and waits out the RAS-to-CAS delay. It then issues the column command with auto-precharge and drives a read-enable or write-enable window to a separate data-path block. A refresh request becomes an AUTO REFRESH command with a one-cycle acknowledge. Four internal down-counters time the gaps: RAS-to-CAS, CAS latency, burst length and the initialization spacing.

Top module: `ddr_cmd_seq`

## Requirements
- R1: While reset is held, the command pins show NOP, and `rd_en`, `wr_en`, `ref_ack` and `init_done` are all low.
- R2: After reset the sequencer issues exactly these six commands in this order. First PRECHARGE with address bit 10 set and bank 0. Then LOAD MODE to bank 1 with address 0 (DLL enabled). Then LOAD MODE to bank 0 with address 0x122 (bit 8 DLL reset, bits 6:4 CAS latency 2, bit 3 sequential, bits 2:0 code 2 for burst 4). Then PRECHARGE with bit 10 set. Then AUTO REFRESH, and then AUTO REFRESH again.
- R3: The first PRECHARGE appears one cycle after reset is released. The next command follows T_RP cycles after each PRECHARGE, T_MRD cycles after each LOAD MODE and T_RFC cycles after each AUTO REFRESH. `init_done` rises T_RFC cycles after the second AUTO REFRESH and stays high.
- R4: A read or write opens the row with ACTIVE, using the latched bank and the row on the address. The READ or WRITE follows T_RCD cycles later with the same bank, the column on the low address bits and bit 10 set. Address inputs that change after acceptance have no effect on that access.
- R5: `rd_en` is high for BURST_LEN/2 consecutive cycles. The window starts CAS_LAT cycles after the READ command.
- R6: `wr_en` is high for BURST_LEN/2 consecutive cycles. The window starts one cycle after the WRITE command.
- R7: A refresh request seen in an idle cycle after initialization produces AUTO REFRESH in the next cycle, with `ref_ack` high for exactly that cycle. No other command follows for T_RFC cycles.
- R8: When several requests are pending in the same idle cycle, refresh is served before read, and read before write.
- R9: Requests raised before `init_done` are held off. The initialization commands and their spacing are unchanged, and `ref_ack` never pulses during initialization.
- R10: Commands are encoded as {cs_n, ras_n, cas_n, we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000. Every cycle that issues no command shows NOP, and chip select stays low.
- R11: A request held ready is accepted as soon as the previous operation ends. The next command appears CAS_LAT + BURST_LEN/2 + 1 cycles after a READ, and BURST_LEN/2 + 2 cycles after a WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usr_rd_req | input | 1 | Read request, held until ACTIVE is seen |
| usr_wr_req | input | 1 | Write request, held until ACTIVE is seen |
| usr_ref_req | input | 1 | Refresh request, held until `ref_ack` |
| usr_row | input | ROW_W | Row address of the request |
| usr_col | input | COL_W | Column address of the request |
| usr_bank | input | BANK_W | Bank of the request |
| ref_ack | output | 1 | One-cycle acknowledge of a user refresh |
| init_done | output | 1 | Power-up sequence complete |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |
| sd_ba | output | BANK_W | SDRAM bank address |
| sd_addr | output | ADDR_W | SDRAM address bus |
| rd_en | output | 1 | Read data window for the data path |
| wr_en | output | 1 | Write data window for the data path |

## Verification
The bench first raises a read request during power-up. This separates correct deferral from an early ACTIVE, and shows whether the init spacing stays intact. Single reads and writes are issued to different banks and to the all-ones row and column; these expose swapped address fields and a missing auto-precharge bit. Requests arrive exactly at the first idle cycle, so an off-by-one in any timer window or in the return to idle shows up as a shifted command. Refresh, read and write are raised together, and also read with write alone, to tell a correct priority from a reversed one.

// File: rtl/ddr_seq_pkg.sv
// Package: shared types for the DDR command sequencer.
// Holds the state encoding, the SDRAM command codes ({cs_n,ras_n,cas_n,we_n})
// and the index of each timer in the timer bank.
package ddr_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_EMRS,
        ST_MRS,
        ST_REF,
        ST_GAP,
        ST_ACT,
        ST_ACT_WAIT,
        ST_RD,
        ST_RD_WAIT,
        ST_RD_DATA,
        ST_WR,
        ST_WR_DATA
    } seq_state_t;

    typedef enum logic [3:0] {
        CMD_MRS   = 4'b0000,
        CMD_REF   = 4'b0001,
        CMD_PRE   = 4'b0010,
        CMD_ACT   = 4'b0011,
        CMD_WRITE = 4'b0100,
        CMD_READ  = 4'b0101,
        CMD_NOP   = 4'b0111
    } sd_cmd_t;

    typedef enum logic [2:0] {
        INIT_PRE1,
        INIT_EMR,
        INIT_MR,
        INIT_PRE2,
        INIT_REF1,
        INIT_REF2,
        INIT_END
    } init_step_t;

    localparam int TMR_RCD   = 0;
    localparam int TMR_CAS   = 1;
    localparam int TMR_BURST = 2;
    localparam int TMR_GAP   = 3;
    localparam int TMR_NUM   = 4;

endpackage

// File: rtl/ddr_seq_timer.sv
// Module: loadable down-counter used for every timing window of the sequencer.
// Assumes: a load pulse places VAL in the counter on the next edge; the
// expired flag is high whenever the counter holds zero, so a window started
// with value L lasts L+1 cycles after the load cycle.
module ddr_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    // Count down to zero after each load; hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr_seq_addr.sv
// Module: address latch and bank/address output mux.
// Latches the request address when the FSM accepts a read or write, then
// drives sd_ba/sd_addr according to the command state. Assumes ADDR_W > AP_BIT
// and COL_W <= AP_BIT so the auto-precharge bit never overlaps the column.
module ddr_seq_addr
    import ddr_seq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter logic [ADDR_W-1:0] MR_VAL  = '0,
    parameter logic [ADDR_W-1:0] EMR_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_en,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [BANK_W-1:0] bank,
    input  seq_state_t        state,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr
);

    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [BANK_W-1:0] bank_q;

    // Capture the request address in the cycle the FSM accepts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            bank_q <= '0;
        end else if (lat_en) begin
            row_q  <= row;
            col_q  <= col;
            bank_q <= bank;
        end
    end

    // Select bank and address lines for the command being issued.
    always_comb begin
        sd_ba   = '0;
        sd_addr = '0;
        case (state)
            ST_PRE:  sd_addr = AP_MASK;
            ST_EMRS: begin
                sd_ba   = BANK_W'(1);
                sd_addr = EMR_VAL;
            end
            ST_MRS:  sd_addr = MR_VAL;
            ST_ACT: begin
                sd_ba   = bank_q;
                sd_addr = ADDR_W'(row_q);
            end
            ST_RD, ST_WR: begin
                sd_ba   = bank_q;
                sd_addr = ADDR_W'(col_q) | AP_MASK;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ddr_seq_fsm.sv
// Module: command state machine of the DDR sequencer.
// Runs the six-step power-up sequence, then serves refresh, read and write
// requests (in that priority) while idle. It loads the timer bank and moves on
// when the matching timer has expired. Assumes the load values already
// account for the state-transition cycles (computed in the top module).
module ddr_seq_fsm
    import ddr_seq_pkg::*;
#(
    parameter int TMR_W    = 8,
    parameter int GAP_RP   = 0,
    parameter int GAP_MRD  = 0,
    parameter int GAP_RFC  = 7,
    parameter int LD_RCD   = 1,
    parameter int LD_CAS   = 0,
    parameter int LD_BURST = 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_req,
    input  logic                             wr_req,
    input  logic                             ref_req,
    input  logic [TMR_NUM-1:0]               tmr_end,
    output logic [TMR_NUM-1:0]               tmr_ld,
    output logic [TMR_NUM-1:0][TMR_W-1:0]    tmr_val,
    output seq_state_t                       state,
    output sd_cmd_t                          cmd,
    output logic                             lat_en,
    output logic                             init_done,
    output logic                             rd_en,
    output logic                             wr_en,
    output logic                             ref_ack
);

    seq_state_t state_q, state_d;
    init_step_t step_q;
    logic       done_q;
    logic       op_rd_q;
    logic       take_ref;
    logic       take_rw;
    logic       init_cmd;

    assign take_ref = done_q && ref_req;
    assign take_rw  = done_q && !ref_req && (rd_req || wr_req);
    assign init_cmd = (state_q == ST_PRE) || (state_q == ST_EMRS) ||
                      (state_q == ST_MRS) || (state_q == ST_REF);

    // Next-state selection for init steps, requests and timer handshakes.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (!done_q) begin
                    case (step_q)
                        INIT_PRE1, INIT_PRE2: state_d = ST_PRE;
                        INIT_EMR:             state_d = ST_EMRS;
                        INIT_MR:              state_d = ST_MRS;
                        INIT_REF1, INIT_REF2: state_d = ST_REF;
                        default:              state_d = ST_IDLE;
                    endcase
                end else if (take_ref) begin
                    state_d = ST_REF;
                end else if (take_rw) begin
                    state_d = ST_ACT;
                end
            end
            ST_PRE, ST_EMRS, ST_MRS, ST_REF: state_d = ST_GAP;
            ST_GAP:      if (tmr_end[TMR_GAP]) state_d = ST_IDLE;
            ST_ACT:      state_d = ST_ACT_WAIT;
            ST_ACT_WAIT: if (tmr_end[TMR_RCD]) state_d = op_rd_q ? ST_RD : ST_WR;
            ST_RD:       state_d = ST_RD_WAIT;
            ST_RD_WAIT:  if (tmr_end[TMR_CAS]) state_d = ST_RD_DATA;
            ST_RD_DATA:  if (tmr_end[TMR_BURST]) state_d = ST_IDLE;
            ST_WR:       state_d = ST_WR_DATA;
            ST_WR_DATA:  if (tmr_end[TMR_BURST]) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State, init progress, done flag and latched operation direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= INIT_PRE1;
            done_q  <= 1'b0;
            op_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (!done_q && init_cmd) begin
                step_q <= init_step_t'(step_q + 3'd1);
            end
            if (state_q == ST_IDLE && step_q == INIT_END) begin
                done_q <= 1'b1;
            end
            if (state_q == ST_IDLE && take_rw) begin
                op_rd_q <= rd_req;
            end
        end
    end

    // Timer load pulses and load values per state.
    always_comb begin
        tmr_ld  = '0;
        tmr_val = '0;
        tmr_ld[TMR_GAP]   = init_cmd;
        case (state_q)
            ST_PRE:  tmr_val[TMR_GAP] = TMR_W'(GAP_RP);
            ST_REF:  tmr_val[TMR_GAP] = TMR_W'(GAP_RFC);
            default: tmr_val[TMR_GAP] = TMR_W'(GAP_MRD);
        endcase
        tmr_ld[TMR_RCD]    = (state_q == ST_ACT);
        tmr_val[TMR_RCD]   = TMR_W'(LD_RCD);
        tmr_ld[TMR_CAS]    = (state_q == ST_RD);
        tmr_val[TMR_CAS]   = TMR_W'(LD_CAS);
        tmr_ld[TMR_BURST]  = (state_q == ST_WR) ||
                             (state_q == ST_RD_WAIT && tmr_end[TMR_CAS]);
        tmr_val[TMR_BURST] = TMR_W'(LD_BURST);
    end

    // Command code for each command-issuing state; NOP elsewhere.
    always_comb begin
        case (state_q)
            ST_PRE:          cmd = CMD_PRE;
            ST_EMRS, ST_MRS: cmd = CMD_MRS;
            ST_REF:          cmd = CMD_REF;
            ST_ACT:          cmd = CMD_ACT;
            ST_RD:           cmd = CMD_READ;
            ST_WR:           cmd = CMD_WRITE;
            default:         cmd = CMD_NOP;
        endcase
    end

    assign state     = state_q;
    assign lat_en    = (state_q == ST_IDLE) && take_rw;
    assign init_done = done_q;
    assign rd_en     = (state_q == ST_RD_DATA);
    assign wr_en     = (state_q == ST_WR_DATA);
    assign ref_ack   = (state_q == ST_REF) && done_q;

endmodule

// File: rtl/ddr_cmd_seq.sv
// Module: top of the DDR SDRAM command sequencer.
// Joins the FSM, the timer bank and the address latch. Timing parameters are
// in clock cycles between command edges. Assumes T_RP, T_MRD, T_RFC >= 3,
// T_RCD >= 2, CAS_LAT in {2,3}, BURST_LEN in {2,4,8}, ADDR_W >= 11, COL_W <= 10.
module ddr_cmd_seq
    import ddr_seq_pkg::*;
#(
    parameter int ROW_W     = 13,
    parameter int COL_W     = 10,
    parameter int BANK_W    = 2,
    parameter int ADDR_W    = 13,
    parameter int CAS_LAT   = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 3,
    parameter int T_RFC     = 10,
    parameter int T_RCD     = 3,
    parameter int TMR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_rd_req,
    input  logic              usr_wr_req,
    input  logic              usr_ref_req,
    input  logic [ROW_W-1:0]  usr_row,
    input  logic [COL_W-1:0]  usr_col,
    input  logic [BANK_W-1:0] usr_bank,
    output logic              ref_ack,
    output logic              init_done,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              rd_en,
    output logic              wr_en
);

    localparam int BURST_CYC = BURST_LEN / 2;
    localparam int GAP_RP    = T_RP - 3;
    localparam int GAP_MRD   = T_MRD - 3;
    localparam int GAP_RFC   = T_RFC - 3;
    localparam int LD_RCD    = T_RCD - 2;
    localparam int LD_CAS    = CAS_LAT - 2;
    localparam int LD_BURST  = BURST_CYC - 1;
    localparam int AP_BIT    = 10;
    localparam logic [ADDR_W-1:0] MR_VAL =
        ADDR_W'((1 << 8) | (CAS_LAT << 4) | $clog2(BURST_LEN));
    localparam logic [ADDR_W-1:0] EMR_VAL = '0;

    logic [TMR_NUM-1:0]            tmr_ld;
    logic [TMR_NUM-1:0]            tmr_end;
    logic [TMR_NUM-1:0][TMR_W-1:0] tmr_val;
    seq_state_t                    state;
    sd_cmd_t                       cmd;
    logic                          lat_en;

    ddr_seq_fsm #(
        .TMR_W    (TMR_W),
        .GAP_RP   (GAP_RP),
        .GAP_MRD  (GAP_MRD),
        .GAP_RFC  (GAP_RFC),
        .LD_RCD   (LD_RCD),
        .LD_CAS   (LD_CAS),
        .LD_BURST (LD_BURST)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (usr_rd_req),
        .wr_req    (usr_wr_req),
        .ref_req   (usr_ref_req),
        .tmr_end   (tmr_end),
        .tmr_ld    (tmr_ld),
        .tmr_val   (tmr_val),
        .state     (state),
        .cmd       (cmd),
        .lat_en    (lat_en),
        .init_done (init_done),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .ref_ack   (ref_ack)
    );

    // One down-counter per timing window.
    for (genvar g = 0; g < TMR_NUM; g++) begin : g_tmr
        ddr_seq_timer #(.W(TMR_W)) i_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (tmr_ld[g]),
            .val     (tmr_val[g]),
            .expired (tmr_end[g])
        );
    end

    ddr_seq_addr #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .BANK_W  (BANK_W),
        .ADDR_W  (ADDR_W),
        .AP_BIT  (AP_BIT),
        .MR_VAL  (MR_VAL),
        .EMR_VAL (EMR_VAL)
    ) i_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lat_en  (lat_en),
        .row     (usr_row),
        .col     (usr_col),
        .bank    (usr_bank),
        .state   (state),
        .sd_ba   (sd_ba),
        .sd_addr (sd_addr)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

endmodule

// File: rtl/ddr_cmd_seq_chk.sv
// Module: protocol checker for the DDR command sequencer, bound to the top.
// Observes only the top-level pins.
module ddr_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] cmd,
    input logic       rd_en,
    input logic       wr_en,
    input logic       ref_ack,
    input logic       init_done
);

    p_cs_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd[3]);

    p_ack_is_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (cmd == 4'b0001));

    p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_no_act_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (cmd != 4'b0011));

    p_no_ack_early_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_ack);

    p_wr_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0100) |=> wr_en);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_rd_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (cmd == 4'b0111));

    p_act_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0011) |=> (cmd == 4'b0111));

endmodule

bind ddr_cmd_seq ddr_cmd_seq_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .ref_ack   (ref_ack),
    .init_done (init_done)
);

// File: tb/test_ddr_cmd_seq.sv
// Scoreboard bench: driver tasks queue expected pin events with their cycle,
// a negedge monitor pops and compares every observed event.
module test_ddr_cmd_seq;

    localparam int ROW_W = 13, COL_W = 10, BANK_W = 2, ADDR_W = 13;
    localparam int CL = 2, BL = 4, BC = BL / 2;
    localparam int T_RP = 3, T_MRD = 3, T_RFC = 10, T_RCD = 3;
    localparam int K_MRS = 0, K_REF = 1, K_PRE = 2, K_ACT = 3, K_WR = 4, K_RD = 5;
    localparam int K_RDEN = 8, K_WREN = 9, K_ACK = 10;
    localparam int AP = 'h400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic usr_rd_req = 1'b0, usr_wr_req = 1'b0, usr_ref_req = 1'b0;
    logic [ROW_W-1:0]  usr_row = '0;
    logic [COL_W-1:0]  usr_col = '0;
    logic [BANK_W-1:0] usr_bank = '0;
    logic ref_ack, init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, rd_en, wr_en;
    logic [BANK_W-1:0] sd_ba;
    logic [ADDR_W-1:0] sd_addr;

    int cyc = 0;
    int n_chk = 0, n_err = 0;
    int free_cyc = 0;
    bit finished = 1'b0;

    int    q_kind[$], q_ba[$], q_addr[$], q_cyc[$];
    string q_tag[$];

    ddr_cmd_seq i_ddr_cmd_seq (
        .clk(clk), .rst_n(rst_n),
        .usr_rd_req(usr_rd_req), .usr_wr_req(usr_wr_req), .usr_ref_req(usr_ref_req),
        .usr_row(usr_row), .usr_col(usr_col), .usr_bank(usr_bank),
        .ref_ack(ref_ack), .init_done(init_done),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .rd_en(rd_en), .wr_en(wr_en)
    );

    always #10 clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic push(input int k, input int ba, input int addr, input int c, input string tag);
        q_kind.push_back(k); q_ba.push_back(ba); q_addr.push_back(addr);
        q_cyc.push_back(c);  q_tag.push_back(tag);
    endtask

    task automatic observe(input int k, input int ba, input int addr);
        int ek, eb, ea, ec;
        string et;
        n_chk++;
        if (q_kind.size() == 0) begin
            n_err++;
            $display("FAIL unexpected event: actual kind %0h ba %0h addr %0h cycle %0d, expected none",
                     k, ba, addr, cyc);
            return;
        end
        ek = q_kind.pop_front(); eb = q_ba.pop_front(); ea = q_addr.pop_front();
        ec = q_cyc.pop_front();  et = q_tag.pop_front();
        if (k != ek || ec != cyc || (k < 8 && (ba != eb || addr != ea))) begin
            n_err++;
            $display("FAIL %s: actual kind %0h ba %0h addr %0h cycle %0d, expected kind %0h ba %0h addr %0h cycle %0d",
                     et, k, ba, addr, cyc, ek, eb, ea, ec);
        end
    endtask

    // Monitor: pop and compare every command and strobe event.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} != 4'b0111)
                observe(int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(sd_ba), int'(sd_addr));
            if (rd_en)   observe(K_RDEN, 0, 0);
            if (wr_en)   observe(K_WREN, 0, 0);
            if (ref_ack) observe(K_ACK, 0, 0);
        end
    end

    task automatic wait_cyc(input int n);
        while (cyc < n) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic push_read(input int a, input int row, input int col, input int bank, input string tag);
        push(K_ACT, bank, row, a, {tag, " R4"});
        push(K_RD, bank, col | AP, a + T_RCD, "R4");
        for (int i = 0; i < BC; i++) push(K_RDEN, 0, 0, a + T_RCD + CL + i, "R5");
    endtask

    task automatic push_write(input int a, input int row, input int col, input int bank, input string tag);
        push(K_ACT, bank, row, a, {tag, " R4"});
        push(K_WR, bank, col | AP, a + T_RCD, "R4");
        for (int i = 0; i < BC; i++) push(K_WREN, 0, 0, a + T_RCD + 1 + i, "R6");
    endtask

    // Driver: raise requests together, predict service in priority order.
    task automatic serve(input bit r, input bit rd, input bit wr, input int row,
                         input int col, input int bank, input string tag);
        int c, a;
        wait_cyc(free_cyc - 1);
        c = cyc;
        usr_row = ROW_W'(row); usr_col = COL_W'(col); usr_bank = BANK_W'(bank);
        usr_ref_req = r; usr_rd_req = rd; usr_wr_req = wr;
        if (r) begin
            push(K_REF, 0, 0, c + 1, {tag, " R7"});
            push(K_ACK, 0, 0, c + 1, "R7");
            wait_cyc(c + 1);
            usr_ref_req = 1'b0;
            c = c + T_RFC;
        end
        if (rd) begin
            a = c + 1;
            push_read(a, row, col, bank, tag);
            wait_cyc(a);
            usr_rd_req = 1'b0;
            c = a + T_RCD + CL + BC;
        end
        if (wr) begin
            a = c + 1;
            push_write(a, row, col, bank, tag);
            wait_cyc(a);
            usr_wr_req = 1'b0;
            c = a + T_RCD + BC + 1;
        end
        usr_row = ~usr_row; usr_col = ~usr_col; usr_bank = ~usr_bank;
        free_cyc = c + 1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        int t;
        // R9: read request raised before init completes.
        usr_row = 13'h0123; usr_col = 10'h045; usr_bank = 2'd1;
        usr_rd_req = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 cmd",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        check(!rd_en && !wr_en && !ref_ack, "R1 strobes", int'({rd_en, wr_en, ref_ack}), 0);
        check(!init_done, "R1 init_done", int'(init_done), 0);
        #1 rst_n = 1'b1;

        // R2 order and R3 spacing of the power-up sequence.
        t = 1;
        push(K_PRE, 0, AP, t, "R2 R3 pre1");
        t += T_RP;  push(K_MRS, 1, 0, t, "R2 R3 emr");
        t += T_MRD; push(K_MRS, 0, 'h122, t, "R2 R3 mr");
        t += T_MRD; push(K_PRE, 0, AP, t, "R2 R3 pre2");
        t += T_RP;  push(K_REF, 0, 0, t, "R2 R3 ref1");
        t += T_RFC; push(K_REF, 0, 0, t, "R2 R3 ref2");
        t += T_RFC;
        push_read(t + 1, 'h0123, 'h045, 1, "R9");

        wait_cyc(t - 1);
        check(!init_done, "R3 done early", int'(init_done), 0);
        wait_cyc(t);
        check(init_done, "R3 done", int'(init_done), 1);
        wait_cyc(t + 1);
        usr_rd_req = 1'b0;
        usr_row = ~usr_row; usr_col = ~usr_col; usr_bank = ~usr_bank;
        free_cyc = t + 1 + T_RCD + CL + BC + 1;

        serve(0, 0, 1, 'h0AAA, 'h155, 2, "R6 R11");
        serve(1, 0, 0, 0, 0, 0, "R7 R11");
        serve(0, 1, 0, 'h1FFF, 'h3FF, 3, "R4 boundary R11");
        serve(0, 1, 0, 'h0000, 'h000, 0, "R11 back-to-back");
        serve(1, 1, 1, 'h0555, 'h2AA, 1, "R8 ref-rd-wr");
        serve(0, 1, 1, 'h1234, 'h0F0, 2, "R8 rd-wr");
        serve(0, 0, 1, 'h0001, 'h001, 3, "R10 R11");

        wait_cyc(free_cyc + 4);
        check(init_done, "R3 done sticky", int'(init_done), 1);
        while (q_kind.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL %s: actual missing, expected kind %0h at cycle %0d",
                     q_tag[0], q_kind[0], q_cyc[0]);
            void'(q_kind.pop_front()); void'(q_ba.pop_front()); void'(q_addr.pop_front());
            void'(q_cyc.pop_front()); void'(q_tag.pop_front());
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout, expected completion");
        finish_run();
    end

endmodule